// File: doc/BRIEF.md
# Block-Edge Deblocking Filter (8-position segment)

This block smooths one 8-position stretch of a block boundary in a decoded picture. For every position along the edge it receives a group of four consecutive pixels that straddle the boundary: p0 and p1 before it, p2 and p3 after it. From the four pixels it forms a signed filter value, shapes that value with a bounding function set by a limit, and moves the two pixels touching the boundary toward each other by the shaped amount. The outer pixels p0 and p3 only feed the computation and leave unchanged.

Groups arrive one per clock under `in_valid`, and each result leaves exactly two clocks later under `out_valid`. A direction bit travels with every group. It says whether the four pixels were taken along a row (the edge is vertical) or down a column (the edge is horizontal). The direction only decides which byte lane of the 32-bit word holds which pixel. Results leave in the same lane order in which they came in.

The limit is sampled once, at the first group of each 8-group segment, and it governs all eight positions of that segment. The bounding function is evaluated with logic and is not held in any table. Edge scheduling across a frame and the derivation of the limit from the quantiser happen outside the block.

Top module: `deblock_seg_filter`

## Requirements
- R1: The raw filter value is floor(((p0 - p3) + 3*(p2 - p1) + 4) / 8), computed in signed arithmetic. Over 8-bit pixels it ranges from -127 to 128.
- R2: For limit L, the correction c equals f(raw). f(x) = x when |x| < L. f(x) = sign(x)*(2L - |x|) when L <= |x| < 2L. f(x) = 0 otherwise. As a result |c| never exceeds L.
- R3: The output p1 is clip(p1 + c) and the output p2 is clip(p2 - c). Each is clamped to the range 0..255.
- R4: The output lanes that carry p0 and p3 equal the input values of those pixels.
- R5: Lane k of a word is bits 8k+7:8k. With in_dir=0 (pixels from a row), lane k holds pk. With in_dir=1 (pixels from a column), lane k holds p(3-k). The output word uses the same ordering as its input group.
- R6: out_valid is high exactly two clocks after each clock in which in_valid is high, and at no other time.
- R7: Valid groups are counted from reset in segments of eight. in_limit is sampled with the first group of a segment and applies to all eight groups of that segment; later values are ignored. out_last is high with the result of the eighth group.
- R8: A segment limit of 0 makes every group pass through unchanged.
- R9: During and right after synchronous reset (rst high), out_valid, out_last and out_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A pixel group is present on in_data |
| in_dir | input | 1 | Lane ordering of the group: 0 = row, 1 = column |
| in_limit | input | 7 | Bounding limit L, sampled at the first group of a segment |
| in_data | input | 32 | Four pixels across the edge |
| out_valid | output | 1 | A filtered group is present on out_data |
| out_last | output | 1 | Result of the eighth group of a segment |
| out_data | output | 32 | Filtered group, in the same lane order as its input |

## Verification
The bench sweeps p2 across its full range against several limits. This drives the raw value through both knees of the bounding function, where an off-by-one in the strict and non-strict comparisons against L and 2L would give a wrong correction. It uses extreme groups that reach raw values of +128 and -127, together with groups that push p1 or p2 past 0 or 255. A design that truncated instead of floored the shift, or that wrapped instead of clamped, would show wrong pixels there. A long random run changes the limit and the direction on every group and inserts idle gaps. That run exposes a design that filters mid-segment with the new limit, counts idle cycles as positions, or mixes up the reversed lanes. A zero-limit segment must come back untouched.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
    parameter int unsigned PIX_W   = 8;
    parameter int unsigned LIM_W   = 7;
    parameter int unsigned LANES   = 4;
    parameter int unsigned SEG_LEN = 8;

    localparam int unsigned RAW_W  = PIX_W + 5;
    localparam int unsigned WORD_W = LANES * PIX_W;

    typedef logic [PIX_W-1:0]             pix_t;
    typedef logic [LIM_W-1:0]             lim_t;
    typedef logic signed [RAW_W-1:0]      raw_t;
    typedef logic [LANES-1:0][PIX_W-1:0]  grp_t;

    typedef struct packed {
        logic v;
        logic last;
        logic dir;
        lim_t lim;
        grp_t grp;
    } stage_t;
endpackage

// File: rtl/edge_lane_order.sv
module edge_lane_order
    import dbf_pkg::*;
(
    input  logic dir,
    input  grp_t din,
    output grp_t dout
);
    // Reversal is its own inverse, so one instance unpacks and another packs.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign dout[k] = dir ? din[LANES-1-k] : din[k];
    end
endmodule

// File: rtl/edge_bound.sv
module edge_bound
    import dbf_pkg::*;
(
    input  raw_t x,
    input  lim_t lim,
    output raw_t y
);
    raw_t ax, l1, l2, mag, ay;

    always_comb begin
        ax  = x[RAW_W-1] ? -x : x;
        l1  = raw_t'(lim);
        l2  = l1 <<< 1;
        mag = l2 - ax;
        if (ax < l1)
            y = x;
        else if (ax < l2)
            y = x[RAW_W-1] ? -mag : mag;
        else
            y = '0;
        ay = y[RAW_W-1] ? -y : y;
        // R2: the shaped correction is never larger than the limit
        a_r2_bound_within_limit: assert (ay <= l1);
    end
endmodule

// File: rtl/edge_core.sv
module edge_core
    import dbf_pkg::*;
(
    input  pix_t p0,
    input  pix_t p1,
    input  pix_t p2,
    input  pix_t p3,
    input  lim_t lim,
    output pix_t q1,
    output pix_t q2
);
    localparam raw_t PMAX = raw_t'((1 << PIX_W) - 1);

    raw_t e0, e1, e2, e3, d21, acc, raw, corr, t1, t2;

    always_comb begin
        e0  = raw_t'(p0);
        e1  = raw_t'(p1);
        e2  = raw_t'(p2);
        e3  = raw_t'(p3);
        d21 = e2 - e1;
        acc = e0 - e3 + (d21 <<< 1) + d21 + raw_t'(4);
        raw = acc >>> 3;
    end

    edge_bound u_bound (
        .x   (raw),
        .lim (lim),
        .y   (corr)
    );

    always_comb begin
        t1 = e1 + corr;
        t2 = e2 - corr;
        if (t1[RAW_W-1])     q1 = '0;
        else if (t1 > PMAX)  q1 = '1;
        else                 q1 = t1[PIX_W-1:0];
        if (t2[RAW_W-1])     q2 = '0;
        else if (t2 > PMAX)  q2 = '1;
        else                 q2 = t2[PIX_W-1:0];
    end
endmodule

// File: rtl/deblock_seg_filter.sv
module deblock_seg_filter
    import dbf_pkg::*;
#(
    parameter int unsigned SEG_N = SEG_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_dir,
    input  logic [LIM_W-1:0]  in_limit,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_last,
    output logic [WORD_W-1:0] out_data
);
    localparam int unsigned POS_W = (SEG_N > 1) ? $clog2(SEG_N) : 1;
    localparam logic [POS_W-1:0] POS_END = POS_W'(SEG_N - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        lim_t             seg_lim;
        stage_t           s1;
        logic             o_valid;
        logic             o_last;
        grp_t             o_data;
    } state_t;

    state_t st_d, st_q;
    grp_t   in_grp, res_grp, out_grp;
    pix_t   q1, q2;
    lim_t   eff_lim;

    edge_lane_order u_unpack (
        .dir  (in_dir),
        .din  (in_data),
        .dout (in_grp)
    );

    edge_core u_core (
        .p0  (st_q.s1.grp[0]),
        .p1  (st_q.s1.grp[1]),
        .p2  (st_q.s1.grp[2]),
        .p3  (st_q.s1.grp[3]),
        .lim (st_q.s1.lim),
        .q1  (q1),
        .q2  (q2)
    );

    always_comb begin
        res_grp    = st_q.s1.grp;
        res_grp[1] = q1;
        res_grp[2] = q2;
    end

    edge_lane_order u_pack (
        .dir  (st_q.s1.dir),
        .din  (res_grp),
        .dout (out_grp)
    );

    always_comb begin
        st_d    = st_q;
        // the first group of a segment uses the limit on the port directly
        eff_lim = (st_q.pos == '0) ? in_limit : st_q.seg_lim;

        if (in_valid) begin
            if (st_q.pos == '0)
                st_d.seg_lim = in_limit;
            st_d.pos = (st_q.pos == POS_END) ? '0 : st_q.pos + 1'b1;
        end

        st_d.s1.v    = in_valid;
        st_d.s1.last = in_valid && (st_q.pos == POS_END);
        st_d.s1.dir  = in_dir;
        st_d.s1.lim  = eff_lim;
        st_d.s1.grp  = in_grp;

        st_d.o_valid = st_q.s1.v;
        st_d.o_last  = st_q.s1.last;
        if (st_q.s1.v)
            st_d.o_data = out_grp;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.o_valid;
    assign out_last  = st_q.o_last;
    assign out_data  = st_q.o_data;

    // R6: every accepted group produces a result two clocks later
    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    // R6: no result without an accepted group two clocks earlier
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    // R4: the end lanes carry p0 and p3 (in either ordering) unchanged
    a_r4_outer_kept: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[PIX_W-1:0] == $past(in_data[PIX_W-1:0], 2)) &&
                      (out_data[WORD_W-1 -: PIX_W] == $past(in_data[WORD_W-1 -: PIX_W], 2)));

    // R7: the segment limit holds after the first group of a segment
    a_r7_limit_held: assert property (@(posedge clk) disable iff (rst)
        (in_valid && st_q.pos != '0) |=> $stable(st_q.seg_lim));
endmodule

// File: tb/tb_deblock_seg_filter.sv
module tb_deblock_seg_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_dir = 1'b0;
    logic [6:0]  in_limit = '0;
    logic [31:0] in_data = '0;
    logic        out_valid, out_last;
    logic [31:0] out_data;

    always #2 clk = ~clk;

    deblock_seg_filter dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dir(in_dir),
        .in_limit(in_limit), .in_data(in_data),
        .out_valid(out_valid), .out_last(out_last), .out_data(out_data)
    );

    int errors = 0, checks = 0, cyc = 0;
    int wr = 0, rd = 0, bpos = 0, blim = 0;
    logic [31:0] exp_data [8192];
    bit          exp_last [8192];
    int          exp_cyc  [8192];
    string       exp_tag  [8192];
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ref_raw(int p0, int p1, int p2, int p3);
        return ((p0 - p3) + 3 * (p2 - p1) + 4) >>> 3;
    endfunction

    function automatic int ref_bound(int x, int l);
        int ax = (x < 0) ? -x : x;
        if (ax < l) return x;
        if (ax < 2 * l) return (x < 0) ? -(2 * l - ax) : (2 * l - ax);
        return 0;
    endfunction

    function automatic int clip8(int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    function automatic logic [31:0] pack4(bit dir, int a0, int a1, int a2, int a3);
        logic [7:0] b0 = a0[7:0], b1 = a1[7:0], b2 = a2[7:0], b3 = a3[7:0];
        return dir ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
    endfunction

    task automatic send(bit dir, int lim, int p0, int p1, int p2, int p3, string tag);
        int c, q1, q2;
        in_valid = 1'b1;
        in_dir   = dir;
        in_limit = lim[6:0];
        in_data  = pack4(dir, p0, p1, p2, p3);
        if (bpos == 0) blim = lim;
        c  = ref_bound(ref_raw(p0, p1, p2, p3), blim);
        q1 = clip8(p1 + c);
        q2 = clip8(p2 - c);
        exp_data[wr] = pack4(dir, p0, q1, q2, p3);
        exp_last[wr] = (bpos == 7);
        exp_cyc[wr]  = cyc + 2;
        exp_tag[wr]  = tag;
        wr++;
        bpos = (bpos + 1) % 8;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid && !done) begin
            checks++;
            if (rd >= wr) begin
                errors++;
                $display("FAIL R6: out_valid with no pending group, data=%h expected none", out_data);
            end else begin
                if (cyc != exp_cyc[rd] || out_data != exp_data[rd] || out_last != exp_last[rd]) begin
                    errors++;
                    $display("FAIL %s: #%0d data=%h last=%0d cyc=%0d expected data=%h last=%0d cyc=%0d",
                             exp_tag[rd], rd, out_data, out_last, cyc,
                             exp_data[rd], exp_last[rd], exp_cyc[rd]);
                end
                rd++;
            end
        end
    end

    task automatic summary();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
    end

    initial begin
        int lims[5] = '{1, 7, 32, 64, 127};
        repeat (3) @(posedge clk);
        #1;
        // R9: outputs cleared by reset
        checks++;
        if (out_valid !== 1'b0 || out_last !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R9: valid=%0d last=%0d data=%h expected 0 0 00000000", out_valid, out_last, out_data);
        end
        rst = 1'b0;
        idle(2);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9: valid=%0d after reset expected 0", out_valid);
        end

        // R8: zero limit segments pass through
        for (int i = 0; i < 64; i++)
            send(i[0], 0, $urandom_range(0, 255), $urandom_range(0, 255),
                 $urandom_range(0, 255), $urandom_range(0, 255), "R8");

        // R1/R2: raw value swept through both knees of the bound
        foreach (lims[j])
            for (int p2 = 0; p2 < 256; p2++)
                send(p2[0], lims[j], 128, 128, p2, 128, "R1/R2 sweep");

        // R2: extreme raw values +128 and -127
        for (int i = 0; i < 4; i++) send(1'b0, 127, 255, 0, 255, 0, "R2 extreme+");
        for (int i = 0; i < 4; i++) send(1'b1, 127, 0, 255, 0, 255, "R2 extreme-");

        // R3: clamping at both ends
        for (int i = 0; i < 4; i++) send(1'b0, 64, 0, 3, 3, 255, "R3 clip low");
        for (int i = 0; i < 4; i++) send(1'b1, 64, 255, 252, 252, 0, "R3 clip high");

        // R1/R2/R3/R4/R5/R7: random groups, limit and direction changing every group, gaps
        for (int i = 0; i < 2000; i++) begin
            send($urandom_range(0, 1), $urandom_range(0, 127), $urandom_range(0, 255),
                 $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
                 "R1/R2/R3/R4/R5/R7 random");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 2));
        end

        // R6: no output after the last group
        idle(12);
        checks++;
        if (rd != wr) begin
            errors++;
            $display("FAIL R6: results seen=%0d expected=%0d", rd, wr);
        end
        summary();
    end
endmodule